// File: doc/BRIEF.md
# Linear CCD Line Clock Sequencer

This block makes every digital gate clock that a two-channel linear CCD with on-chip correlated double sampling needs. It drives the photodiode transfer gate, the two complementary shift-register phases, the floating-diffusion reset clock and the clamp and sample clocks of the double-sampling circuit. While the block is idle the array integrates. The transfer gate stays closed and both register phases are held low.

A line-start pulse that arrives while the block is idle starts a line. The block first runs a transfer window in which phase 1 and the transfer gate open together. It then reads out every pixel pair in a fixed sequence of segments. The segment lengths are set in system clocks by configuration inputs, so the same block can serve different pixel rates. Odd pixels leave on channel A and even pixels on channel B, so each shift delivers one pair. After each sample pulse a valid strobe carries the pair index, so later logic can rebuild the line in pixel order: pair k holds pixel 2k+1 on channel A and pixel 2k+2 on channel B. A one-cycle line-done pulse marks the end of the readout.

Top module: `ccd_line_timer`

## Requirements
- R1: After synchronous reset, all gate clocks, `pix_valid_o`, `line_done_o` and `overrun_o` are low and the block is idle.
- R2: An accepted line start is followed by G cycles with every clock low. Then `tg_o` and `phi1_o` are high together for X cycles while `phi2_o` is low. Then `tg_o` is low with `phi1_o` still high for G cycles. Then every clock is low for G cycles.
- R3: `phi1_o` and `phi2_o` are never high in the same cycle. A phase never rises in the cycle right after the other phase was high.
- R4: Each pixel period runs these segments in order: `fdrst_o` with `phi2_o` high for R cycles; `clamp_o` with `phi2_o` high for C cycles; `phi2_o` falls and all clocks are low for G cycles; `sample_o` with `phi1_o` high for S cycles; all clocks low for G cycles. The period is P = R+C+2G+S.
- R5: One line contains exactly PAIRS = NUM_PIXELS/2 falling edges of `phi2_o`, which is 2500 with the default of 5000 pixels.
- R6: `pix_valid_o` is high for one cycle, in the cycle right after the last cycle of each sample pulse. It comes with `pix_index_o`, which counts 0, 1, … PAIRS-1 in order.
- R7: `line_done_o` is high for exactly one cycle. That cycle is the first idle cycle after the final guard of the last pair: the accept cycle plus 3G+X+PAIRS·P. In that cycle all gate clocks are low.
- R8: A line start that arrives while a line is running has no effect on the clock sequence. It sets `overrun_o`, which stays high until reset.
- R9: A length input programmed to 0 acts exactly like a length of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| line_start_i | input | 1 | Request to transfer and read out a line |
| cfg_reset_len_i | input | LEN_W | Reset pulse length R |
| cfg_clamp_len_i | input | LEN_W | Clamp pulse length C |
| cfg_sample_len_i | input | LEN_W | Sample pulse length S |
| cfg_guard_len_i | input | LEN_W | Non-overlap guard length G |
| cfg_xfer_len_i | input | LEN_W | Transfer gate open length X |
| tg_o | output | 1 | Photodiode transfer gate |
| phi1_o | output | 1 | Register phase 1 |
| phi2_o | output | 1 | Register phase 2 |
| fdrst_o | output | 1 | Floating diffusion reset clock |
| clamp_o | output | 1 | Double-sampling clamp clock |
| sample_o | output | 1 | Double-sampling sample clock |
| pix_valid_o | output | 1 | Pixel pair sampled strobe |
| pix_index_o | output | IDX_W | Pair index of the strobe |
| line_done_o | output | 1 | End-of-line pulse |
| overrun_o | output | 1 | Sticky flag for a line start that was ignored |

## Verification
The assertions assume that the length inputs do not change while a line is in progress, because a change in the middle of a segment would move its end. They also assume that reset is applied synchronously at power-up. Line starts may arrive at any time, and nothing is assumed about them. The stimulus changes the configuration only in idle gaps between lines. It deliberately pulses `line_start_i` in the middle of a readout, so that the ignore path runs while the clock-relation assertions stay in force.

// File: rtl/ccd_timing_pkg.sv
package ccd_timing_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_X_PRE,
    ST_X_OPEN,
    ST_X_POST,
    ST_X_DROP,
    ST_P_RST,
    ST_P_CLAMP,
    ST_P_FALL,
    ST_P_SAMPLE,
    ST_P_GAP
  } line_state_e;

  localparam int SEG_RST    = 0;
  localparam int SEG_CLAMP  = 1;
  localparam int SEG_SAMPLE = 2;
  localparam int SEG_GUARD  = 3;
  localparam int SEG_XFER   = 4;
  localparam int NUM_SEG    = 5;

  typedef struct packed {
    logic tg;
    logic phi1;
    logic phi2;
    logic fdrst;
    logic clamp;
    logic sample;
  } clk_levels_t;

endpackage

// File: rtl/ccd_seg_len.sv
module ccd_seg_len #(
  parameter int LEN_W = 8,
  parameter int NSEG  = 5
) (
  input  logic [NSEG-1:0][LEN_W-1:0] raw_i,
  output logic [NSEG-1:0][LEN_W-1:0] eff_o
);
  localparam logic [LEN_W-1:0] ONE = {{(LEN_W-1){1'b0}}, 1'b1};

  for (genvar g = 0; g < NSEG; g++) begin : g_clip
    assign eff_o[g] = (raw_i[g] == '0) ? ONE : raw_i[g];
  end
endmodule

// File: rtl/ccd_seg_timer.sv
module ccd_seg_timer #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             done_o
);
  logic [LEN_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || restart_i) cnt_q <= '0;
    else                  cnt_q <= cnt_q + LEN_W'(1);
  end

  assign done_o = (cnt_q == len_i - LEN_W'(1));

  assert_seg_in_range_R9: assert property (@(posedge clk) disable iff (rst)
    (len_i != '0) |-> (cnt_q < len_i));
endmodule

// File: rtl/ccd_pair_counter.sv
module ccd_pair_counter #(
  parameter int PAIRS = 2500,
  parameter int IDX_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_i,
  input  logic             step_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             last_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(PAIRS - 1);

  always_ff @(posedge clk) begin
    if (rst || clear_i) idx_o <= '0;
    else if (step_i)    idx_o <= idx_o + IDX_W'(1);
  end

  assign last_o = (idx_o == LAST);

  assert_index_bound_R6: assert property (@(posedge clk) disable iff (rst)
    idx_o <= LAST);
endmodule

// File: rtl/ccd_clock_decode.sv
module ccd_clock_decode
  import ccd_timing_pkg::*;
(
  input  line_state_e state_i,
  output clk_levels_t lv_o
);
  always_comb begin
    lv_o = '0;
    unique case (state_i)
      ST_X_OPEN:   begin lv_o.tg = 1'b1; lv_o.phi1 = 1'b1; end
      ST_X_POST:   lv_o.phi1 = 1'b1;
      ST_P_RST:    begin lv_o.phi2 = 1'b1; lv_o.fdrst = 1'b1; end
      ST_P_CLAMP:  begin lv_o.phi2 = 1'b1; lv_o.clamp = 1'b1; end
      ST_P_SAMPLE: begin lv_o.phi1 = 1'b1; lv_o.sample = 1'b1; end
      default:     lv_o = '0;
    endcase
  end
endmodule

// File: rtl/ccd_line_timer.sv
module ccd_line_timer
  import ccd_timing_pkg::*;
#(
  parameter int NUM_PIXELS   = 5000,
  parameter int NUM_CHANNELS = 2,
  parameter int LEN_W        = 8,
  localparam int PAIRS       = NUM_PIXELS / NUM_CHANNELS,
  localparam int IDX_W       = (PAIRS > 1) ? $clog2(PAIRS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_start_i,
  input  logic [LEN_W-1:0] cfg_reset_len_i,
  input  logic [LEN_W-1:0] cfg_clamp_len_i,
  input  logic [LEN_W-1:0] cfg_sample_len_i,
  input  logic [LEN_W-1:0] cfg_guard_len_i,
  input  logic [LEN_W-1:0] cfg_xfer_len_i,
  output logic             tg_o,
  output logic             phi1_o,
  output logic             phi2_o,
  output logic             fdrst_o,
  output logic             clamp_o,
  output logic             sample_o,
  output logic             pix_valid_o,
  output logic [IDX_W-1:0] pix_index_o,
  output logic             line_done_o,
  output logic             overrun_o
);

  line_state_e state_q, state_n;
  logic [NUM_SEG-1:0][LEN_W-1:0] raw_len, eff_len;
  logic [LEN_W-1:0] cur_len;
  logic             seg_done, seg_restart;
  logic [IDX_W-1:0] pair_idx;
  logic             pair_last, pair_clear, pair_step;
  clk_levels_t      lv_n, lv_q;

  assign raw_len[SEG_RST]    = cfg_reset_len_i;
  assign raw_len[SEG_CLAMP]  = cfg_clamp_len_i;
  assign raw_len[SEG_SAMPLE] = cfg_sample_len_i;
  assign raw_len[SEG_GUARD]  = cfg_guard_len_i;
  assign raw_len[SEG_XFER]   = cfg_xfer_len_i;

  ccd_seg_len #(.LEN_W(LEN_W), .NSEG(NUM_SEG)) u_len (
    .raw_i (raw_len),
    .eff_o (eff_len)
  );

  always_comb begin
    unique case (state_q)
      ST_X_OPEN:   cur_len = eff_len[SEG_XFER];
      ST_P_RST:    cur_len = eff_len[SEG_RST];
      ST_P_CLAMP:  cur_len = eff_len[SEG_CLAMP];
      ST_P_SAMPLE: cur_len = eff_len[SEG_SAMPLE];
      ST_IDLE:     cur_len = {{(LEN_W-1){1'b0}}, 1'b1};
      default:     cur_len = eff_len[SEG_GUARD];
    endcase
  end

  assign seg_restart = (state_q == ST_IDLE) || seg_done;

  ccd_seg_timer #(.LEN_W(LEN_W)) u_seg (
    .clk       (clk),
    .rst       (rst),
    .restart_i (seg_restart),
    .len_i     (cur_len),
    .done_o    (seg_done)
  );

  assign pair_clear = (state_q == ST_X_DROP);
  assign pair_step  = (state_q == ST_P_GAP) && seg_done && !pair_last;

  ccd_pair_counter #(.PAIRS(PAIRS), .IDX_W(IDX_W)) u_pair (
    .clk     (clk),
    .rst     (rst),
    .clear_i (pair_clear),
    .step_i  (pair_step),
    .idx_o   (pair_idx),
    .last_o  (pair_last)
  );

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      ST_IDLE:     if (line_start_i) state_n = ST_X_PRE;
      ST_X_PRE:    if (seg_done) state_n = ST_X_OPEN;
      ST_X_OPEN:   if (seg_done) state_n = ST_X_POST;
      ST_X_POST:   if (seg_done) state_n = ST_X_DROP;
      ST_X_DROP:   if (seg_done) state_n = ST_P_RST;
      ST_P_RST:    if (seg_done) state_n = ST_P_CLAMP;
      ST_P_CLAMP:  if (seg_done) state_n = ST_P_FALL;
      ST_P_FALL:   if (seg_done) state_n = ST_P_SAMPLE;
      ST_P_SAMPLE: if (seg_done) state_n = ST_P_GAP;
      ST_P_GAP:    if (seg_done) state_n = pair_last ? ST_IDLE : ST_P_RST;
      default:     state_n = ST_IDLE;
    endcase
  end

  ccd_clock_decode u_dec (
    .state_i (state_n),
    .lv_o    (lv_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      lv_q        <= '0;
      pix_valid_o <= 1'b0;
      pix_index_o <= '0;
      line_done_o <= 1'b0;
      overrun_o   <= 1'b0;
    end else begin
      state_q     <= state_n;
      lv_q        <= lv_n;
      pix_valid_o <= (state_q == ST_P_SAMPLE) && seg_done;
      if ((state_q == ST_P_SAMPLE) && seg_done) pix_index_o <= pair_idx;
      line_done_o <= (state_q == ST_P_GAP) && seg_done && pair_last;
      if (line_start_i && (state_q != ST_IDLE)) overrun_o <= 1'b1;
    end
  end

  assign tg_o     = lv_q.tg;
  assign phi1_o   = lv_q.phi1;
  assign phi2_o   = lv_q.phi2;
  assign fdrst_o  = lv_q.fdrst;
  assign clamp_o  = lv_q.clamp;
  assign sample_o = lv_q.sample;

  assert_phase_excl_R3: assert property (@(posedge clk) disable iff (rst)
    !(phi1_o && phi2_o));
  assert_phi1_guard_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(phi1_o) |-> !$past(phi2_o));
  assert_phi2_guard_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(phi2_o) |-> !$past(phi1_o));
  assert_tg_with_phi1_R2: assert property (@(posedge clk) disable iff (rst)
    tg_o |-> (phi1_o && !phi2_o));
  assert_tg_close_hold_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(tg_o) |-> phi1_o);
  assert_cds_onehot_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({fdrst_o, clamp_o, sample_o}));
  assert_clamp_after_reset_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(clamp_o) |-> $past(fdrst_o));
  assert_valid_after_sample_R6: assert property (@(posedge clk) disable iff (rst)
    pix_valid_o |-> ($past(sample_o) && !sample_o));
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    line_done_o |=> !line_done_o);
  assert_done_idle_R7: assert property (@(posedge clk) disable iff (rst)
    line_done_o |-> !(tg_o || phi1_o || phi2_o));
  assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    overrun_o |=> overrun_o);

endmodule

// File: tb/tb_ccd_line_timer.sv
module tb_ccd_line_timer;
  localparam int CLK_PERIOD = 10;
  localparam int NPIX  = 5000;
  localparam int PAIRS = NPIX / 2;
  localparam int IDX_W = $clog2(PAIRS);
  localparam int WD_LIMIT = 190000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic line_start = 1'b0;
  logic [7:0] c_rst = 8'd1, c_clamp = 8'd1, c_smp = 8'd1, c_grd = 8'd1, c_xfr = 8'd1;
  logic tg, phi1, phi2, fdrst, clamp, sample, pvalid, ldone, ovr;
  logic [IDX_W-1:0] pidx;

  always #(CLK_PERIOD/2) clk = ~clk;

  ccd_line_timer #(.NUM_PIXELS(NPIX), .NUM_CHANNELS(2), .LEN_W(8)) dut (
    .clk(clk), .rst(rst), .line_start_i(line_start),
    .cfg_reset_len_i(c_rst), .cfg_clamp_len_i(c_clamp), .cfg_sample_len_i(c_smp),
    .cfg_guard_len_i(c_grd), .cfg_xfer_len_i(c_xfr),
    .tg_o(tg), .phi1_o(phi1), .phi2_o(phi2), .fdrst_o(fdrst), .clamp_o(clamp),
    .sample_o(sample), .pix_valid_o(pvalid), .pix_index_o(pidx),
    .line_done_o(ldone), .overrun_o(ovr)
  );

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  int total_cyc = 0;

  typedef struct { int idx; int at; } exp_item_t;
  exp_item_t exp_q[$];

  int exp_done_at, exp_tg_at, exp_tg_len;
  bit line_ended;
  int phi2_falls, tg_first, tg_len, seq_bad, ovl_bad;
  bit prev_phi1, prev_phi2, prev_tg;

  task automatic check(bit ok, string req, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    total_cyc <= total_cyc + 1;
  end

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (phi1 && phi2) ovl_bad++;
      if ((phi1 && prev_phi2) || (phi2 && prev_phi1)) ovl_bad++;
      if ((fdrst && !phi2) || (clamp && !phi2) || (sample && !phi1)) seq_bad++;
      if (prev_phi2 && !phi2) phi2_falls++;
      if (tg && !prev_tg) tg_first = cyc;
      if (tg) tg_len++;
      if (pvalid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R6 unexpected valid", int'(pidx), -1);
        end else begin
          exp_item_t e;
          e = exp_q.pop_front();
          check(int'(pidx) == e.idx, "R6 pair index", int'(pidx), e.idx);
          check(cyc == e.at, "R4 valid timing", cyc, e.at);
        end
      end
      if (ldone) begin
        check(cyc == exp_done_at, "R7 done cycle", cyc, exp_done_at);
        check(!(tg || phi1 || phi2), "R7 clocks idle at done", int'({tg, phi1, phi2}), 0);
        check(phi2_falls == PAIRS, "R5 phi2 falls per line", phi2_falls, PAIRS);
        check(tg_first == exp_tg_at, "R2 transfer gate start", tg_first, exp_tg_at);
        check(tg_len == exp_tg_len, "R2 transfer gate length", tg_len, exp_tg_len);
        check(exp_q.size() == 0, "R6 all pairs delivered", exp_q.size(), 0);
        line_ended = 1'b1;
      end
      prev_phi1 = phi1;
      prev_phi2 = phi2;
      prev_tg   = tg;
    end
  end

  function automatic int eff(logic [7:0] v);
    return (v == 8'd0) ? 1 : int'(v);
  endfunction

  // Driver: starts a line and pushes its expected results
  task automatic run_line(logic [7:0] r, logic [7:0] c, logic [7:0] s,
                          logic [7:0] g, logic [7:0] x, bit inject, string tag);
    int n0, base, per, wd;
    @(negedge clk);
    c_rst = r; c_clamp = c; c_smp = s; c_grd = g; c_xfr = x;
    phi2_falls = 0; tg_len = 0; tg_first = -1; line_ended = 1'b0;
    line_start = 1'b1;
    @(negedge clk);
    line_start = 1'b0;
    n0   = cyc;
    per  = eff(r) + eff(c) + 2 * eff(g) + eff(s);
    base = n0 + 3 * eff(g) + eff(x);
    exp_tg_at  = n0 + eff(g);
    exp_tg_len = eff(x);
    exp_done_at = base + PAIRS * per;
    for (int p = 0; p < PAIRS; p++) begin
      exp_item_t e;
      e.idx = p;
      e.at  = base + p * per + eff(r) + eff(c) + eff(g) + eff(s);
      exp_q.push_back(e);
    end
    wd = 0;
    while (!line_ended && total_cyc < WD_LIMIT) begin
      @(negedge clk);
      wd++;
      if (inject && wd == 137) begin
        line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
      end
    end
    if (!line_ended) check(1'b0, {tag, " watchdog"}, wd, 0);
    exp_q.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check({tg, phi1, phi2, fdrst, clamp, sample} == 6'd0, "R1 clocks low", int'({tg, phi1, phi2, fdrst, clamp, sample}), 0);
    check({pvalid, ldone, ovr} == 3'd0, "R1 flags low", int'({pvalid, ldone, ovr}), 0);

    run_line(8'd1, 8'd1, 8'd1, 8'd1, 8'd1, 1'b0, "R2 line1");
    check(ovr == 1'b0, "R8 no overrun on clean line", int'(ovr), 0);
    repeat (4) @(negedge clk);
    check(!(tg || phi1 || phi2), "R7 idle clocks low", int'({tg, phi1, phi2}), 0);

    // Mid-line trigger must be ignored (R8)
    run_line(8'd2, 8'd3, 8'd1, 8'd2, 8'd4, 1'b1, "R8 line2");
    check(ovr == 1'b1, "R8 overrun set", int'(ovr), 1);

    // Zero lengths behave as one (R9)
    run_line(8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 1'b0, "R9 line3");
    check(ovr == 1'b1, "R8 overrun sticky", int'(ovr), 1);

    check(ovl_bad == 0, "R3 phase overlap or guard", ovl_bad, 0);
    check(seq_bad == 0, "R4 pulse/phase pairing", seq_bad, 0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule